// File: doc/BRIEF.md
# Pending List-Register Priority Selector

The selector looks at a bank of virtual interrupt list registers and chooses the one pending entry that should be offered to the virtual processor. Each entry carries a two-bit state, a group bit, a non-maskable (NMI) bit and an 8-bit priority, where a lower number means a more urgent interrupt.

The scan keeps the numerically lowest priority. At equal priority an NMI entry beats an ordinary one. After the scan, the chosen entry is tested for preemption. The tests use the virtual priority mask, a per-group binary point that sets how many priority bits take part in the comparison, a summary of the active priorities, and a flag that says an NMI is already being serviced. A global enable gates the preemption decision. If that decision succeeds, the entry raises exactly one of three levels: FIQ for group 0, NMI for group 1 entries with the NMI bit set, and IRQ for the other group 1 entries.

All results are registered. They follow any change on the inputs one clock later. Acknowledge and end-of-interrupt handling belong to the surrounding logic.

Top module: `vlr_pend_sel`

## Requirements
- R1: While reset is held low at a clock edge, `sel_valid_o`, `sel_idx_o`, `fiq_o`, `irq_o` and `nmi_o` are all zero after that edge.
- R2: Only an entry whose state is pending (encoding 2'b01) is a candidate. The encodings 2'b00 (invalid), 2'b10 (active) and 2'b11 (pending and active) are never candidates. A candidate also needs its group to be enabled: group bit 0 uses `grp0_en_i` and group bit 1 uses `grp1_en_i`. With no candidate, `sel_valid_o` is 0 and all three lines are low.
- R3: The selected entry has the numerically lowest priority. Among non-NMI entries of equal priority, the lowest index is kept. A non-NMI entry at priority 0xFF is never selected.
- R4: At equal priority, an entry with its NMI bit set replaces a non-NMI choice whatever the indices are. An NMI entry at priority 0xFF can be selected.
- R5: A selected non-NMI entry whose priority is greater than or equal to `vpmr_i` raises no line. An NMI entry ignores `vpmr_i`.
- R6: Preemption compares priorities through a group mask. The group 0 mask is 0xFF shifted left by `bpr0_i`+1 and the group 1 mask is 0xFF shifted left by `bpr1_i`. When no priority is active, the entry preempts. Otherwise it preempts only when its masked priority is strictly below the masked running priority.
- R7: The running priority is k·2^(8−PRE_BITS), where k is the lowest set bit of `apr_i`. At equal masked priority, an NMI entry still preempts, provided `act_nmi_i` is clear.
- R8: When `act_nmi_i` is set, the running priority is 0x00 and no entry preempts.
- R9: A preempting group 0 entry raises `fiq_o`. A preempting group 1 entry raises `nmi_o` if its NMI bit is set and `irq_o` otherwise. At most one line is high.
- R10: With `hyp_en_i` clear no line is raised, but `sel_valid_o` and `sel_idx_o` still report the selection.
- R11: With parameter NMI_EN = 0, every NMI bit is treated as zero. Such entries get no tie win and no mask bypass, route to `irq_o`, and `nmi_o` stays low.
- R12: Each output takes the value implied by the inputs at the previous rising clock edge, so it changes exactly one cycle after an input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lr_state_i | input | NUM_LR×2 | Per-entry state: 00 invalid, 01 pending, 10 active, 11 pending and active |
| lr_group_i | input | NUM_LR | Per-entry group (0 or 1) |
| lr_nmi_i | input | NUM_LR | Per-entry non-maskable flag |
| lr_prio_i | input | NUM_LR×8 | Per-entry priority, lower is more urgent |
| grp0_en_i | input | 1 | Group 0 enable |
| grp1_en_i | input | 1 | Group 1 enable |
| hyp_en_i | input | 1 | Global enable for preemption |
| vpmr_i | input | 8 | Virtual priority mask |
| bpr0_i | input | 3 | Group 0 binary point |
| bpr1_i | input | 3 | Group 1 binary point |
| apr_i | input | 2^PRE_BITS | Active group-priority summary, bit k = level k·2^(8−PRE_BITS) |
| act_nmi_i | input | 1 | An NMI is currently active |
| sel_idx_o | output | clog2(NUM_LR) | Index of the selected entry |
| sel_valid_o | output | 1 | A pending, enabled entry was selected |
| fiq_o | output | 1 | FIQ level |
| irq_o | output | 1 | IRQ level |
| nmi_o | output | 1 | NMI level |

## Verification
The bench builds two copies side by side from the same stimulus. Both use four entries and five priority bits, so one active-summary bit spans eight priority values. One copy has NMI_EN = 1 and the other has NMI_EN = 0. The four entries are enough to set up index ties, NMI ties against lower indices, and skipped active entries. The five-bit summary lets group masks from 0xFE to 0xC0 merge priorities into equal groups. Placing the two NMI settings next to each other shows directly that tie wins, mask bypass and NMI routing disappear when the support is off.

// File: rtl/vlr_sel_pkg.sv
// Package: shared constants and the list-register state encoding for the
// pending list-register selector. Assumes 8-bit priorities throughout.
package vlr_sel_pkg;
    localparam int PRIO_W = 8;
    localparam int BPR_W  = 3;

    typedef enum logic [1:0] {
        LR_INVALID  = 2'b00,
        LR_PEND     = 2'b01,
        LR_ACT      = 2'b10,
        LR_PEND_ACT = 2'b11
    } lr_state_e;
endpackage

// File: rtl/vlr_scan.sv
// Module: vlr_scan
// Combinational scan over all list registers. It picks the pending entry
// with the lowest priority number; at equal priority an NMI entry beats a
// non-NMI choice. The running best starts at all-ones, so an ordinary entry
// at the weakest priority never wins. NMI_EN = 0 clears every NMI bit.
module vlr_scan
    import vlr_sel_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int NMI_EN = 1,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic [NUM_LR-1:0][1:0]        lr_state_i,
    input  logic [NUM_LR-1:0]             lr_group_i,
    input  logic [NUM_LR-1:0]             lr_nmi_i,
    input  logic [NUM_LR-1:0][PRIO_W-1:0] lr_prio_i,
    input  logic                          grp0_en_i,
    input  logic                          grp1_en_i,
    output logic [IDX_W-1:0]              best_idx_o,
    output logic                          best_valid_o,
    output logic [PRIO_W-1:0]             best_prio_o,
    output logic                          best_nmi_o,
    output logic                          best_grp_o
);
    localparam logic NMI_KEEP = (NMI_EN != 0);

    logic [NUM_LR-1:0] cand;
    logic [NUM_LR-1:0] eff_nmi;

    // Per-entry candidacy and effective NMI bit.
    for (genvar g = 0; g < NUM_LR; g++) begin : g_entry
        assign cand[g]    = (lr_state_i[g] == LR_PEND) &&
                            (lr_group_i[g] ? grp1_en_i : grp0_en_i);
        assign eff_nmi[g] = lr_nmi_i[g] & NMI_KEEP;
    end

    // Ascending scan keeping the strongest candidate seen so far.
    always_comb begin
        best_prio_o  = '1;
        best_nmi_o   = 1'b0;
        best_valid_o = 1'b0;
        best_idx_o   = '0;
        best_grp_o   = 1'b0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (cand[i] && ((lr_prio_i[i] < best_prio_o) ||
                            ((lr_prio_i[i] == best_prio_o) && eff_nmi[i] && !best_nmi_o))) begin
                best_prio_o  = lr_prio_i[i];
                best_nmi_o   = eff_nmi[i];
                best_valid_o = 1'b1;
                best_idx_o   = IDX_W'(i);
                best_grp_o   = lr_group_i[i];
            end
        end
    end
endmodule

// File: rtl/vrun_prio.sv
// Module: vrun_prio
// Turns the active group-priority summary into a running priority. The
// lowest set bit k gives k << (8 - PRE_BITS). An active NMI forces 0x00.
// Assumes PRE_BITS is between 1 and 8.
module vrun_prio
    import vlr_sel_pkg::*;
#(
    parameter int PRE_BITS = 5,
    localparam int APR_W = 1 << PRE_BITS,
    localparam int SHIFT = PRIO_W - PRE_BITS
) (
    input  logic [APR_W-1:0]  apr_i,
    input  logic              act_nmi_i,
    output logic [PRIO_W-1:0] rprio_o,
    output logic              has_act_o
);
    // Descending walk so the last hit is the lowest set bit.
    always_comb begin
        rprio_o   = '1;
        has_act_o = 1'b0;
        for (int k = APR_W - 1; k >= 0; k--) begin
            if (apr_i[k]) begin
                rprio_o   = PRIO_W'(k << SHIFT);
                has_act_o = 1'b1;
            end
        end
        if (act_nmi_i) begin
            rprio_o   = '0;
            has_act_o = 1'b1;
        end
    end
endmodule

// File: rtl/vpre_chk.sv
// Module: vpre_chk
// Decides whether the selected entry may preempt. It applies the global
// enable, the priority mask (bypassed by NMI entries) and a masked
// comparison against the running priority, where an NMI may also win at
// equal masked priority when no NMI is active.
module vpre_chk
    import vlr_sel_pkg::*;
(
    input  logic              sel_valid_i,
    input  logic [PRIO_W-1:0] sel_prio_i,
    input  logic              sel_nmi_i,
    input  logic              sel_grp_i,
    input  logic              hyp_en_i,
    input  logic [PRIO_W-1:0] vpmr_i,
    input  logic [BPR_W-1:0]  bpr0_i,
    input  logic [BPR_W-1:0]  bpr1_i,
    input  logic [PRIO_W-1:0] rprio_i,
    input  logic              has_act_i,
    input  logic              act_nmi_i,
    output logic              can_pre_o
);
    logic [PRIO_W-1:0] gmask;
    logic [PRIO_W-1:0] cand_g;
    logic [PRIO_W-1:0] run_g;

    // Group priority mask built from the binary point of the entry's group.
    always_comb begin
        if (sel_grp_i) gmask = {PRIO_W{1'b1}} << bpr1_i;
        else           gmask = {PRIO_W{1'b1}} << ({1'b0, bpr0_i} + 4'd1);
        cand_g = sel_prio_i & gmask;
        run_g  = rprio_i & gmask;
    end

    // Preemption decision.
    always_comb begin
        can_pre_o = 1'b0;
        if (hyp_en_i && sel_valid_i && (sel_nmi_i || (sel_prio_i < vpmr_i))) begin
            if (!has_act_i)                                 can_pre_o = 1'b1;
            else if (cand_g < run_g)                        can_pre_o = 1'b1;
            else if ((cand_g == run_g) && sel_nmi_i && !act_nmi_i) can_pre_o = 1'b1;
        end
    end
endmodule

// File: rtl/vlr_pend_sel.sv
// Module: vlr_pend_sel (top)
// Selects the strongest pending virtual list-register entry, checks it for
// preemption and drives FIQ, IRQ or NMI. Every output is registered and
// follows the inputs one cycle later. The reset is synchronous, active low.
module vlr_pend_sel
    import vlr_sel_pkg::*;
#(
    parameter int NUM_LR   = 4,
    parameter int PRE_BITS = 5,
    parameter int NMI_EN   = 1,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
    localparam int APR_W = 1 << PRE_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LR-1:0][1:0]        lr_state_i,
    input  logic [NUM_LR-1:0]             lr_group_i,
    input  logic [NUM_LR-1:0]             lr_nmi_i,
    input  logic [NUM_LR-1:0][PRIO_W-1:0] lr_prio_i,
    input  logic                          grp0_en_i,
    input  logic                          grp1_en_i,
    input  logic                          hyp_en_i,
    input  logic [PRIO_W-1:0]             vpmr_i,
    input  logic [BPR_W-1:0]              bpr0_i,
    input  logic [BPR_W-1:0]              bpr1_i,
    input  logic [APR_W-1:0]              apr_i,
    input  logic                          act_nmi_i,
    output logic [IDX_W-1:0]              sel_idx_o,
    output logic                          sel_valid_o,
    output logic                          fiq_o,
    output logic                          irq_o,
    output logic                          nmi_o
);
    logic [IDX_W-1:0]  best_idx;
    logic              best_valid;
    logic [PRIO_W-1:0] best_prio;
    logic              best_nmi;
    logic              best_grp;
    logic [PRIO_W-1:0] rprio;
    logic              has_act;
    logic              can_pre;

    vlr_scan #(.NUM_LR(NUM_LR), .NMI_EN(NMI_EN)) u_scan (
        .lr_state_i   (lr_state_i),
        .lr_group_i   (lr_group_i),
        .lr_nmi_i     (lr_nmi_i),
        .lr_prio_i    (lr_prio_i),
        .grp0_en_i    (grp0_en_i),
        .grp1_en_i    (grp1_en_i),
        .best_idx_o   (best_idx),
        .best_valid_o (best_valid),
        .best_prio_o  (best_prio),
        .best_nmi_o   (best_nmi),
        .best_grp_o   (best_grp)
    );

    vrun_prio #(.PRE_BITS(PRE_BITS)) u_run (
        .apr_i     (apr_i),
        .act_nmi_i (act_nmi_i),
        .rprio_o   (rprio),
        .has_act_o (has_act)
    );

    vpre_chk u_pre (
        .sel_valid_i (best_valid),
        .sel_prio_i  (best_prio),
        .sel_nmi_i   (best_nmi),
        .sel_grp_i   (best_grp),
        .hyp_en_i    (hyp_en_i),
        .vpmr_i      (vpmr_i),
        .bpr0_i      (bpr0_i),
        .bpr1_i      (bpr1_i),
        .rprio_i     (rprio),
        .has_act_i   (has_act),
        .act_nmi_i   (act_nmi_i),
        .can_pre_o   (can_pre)
    );

    // Output registers: selection and routed interrupt lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx_o   <= '0;
            sel_valid_o <= 1'b0;
            fiq_o       <= 1'b0;
            irq_o       <= 1'b0;
            nmi_o       <= 1'b0;
        end else begin
            sel_idx_o   <= best_idx;
            sel_valid_o <= best_valid;
            fiq_o       <= can_pre && !best_grp;
            irq_o       <= can_pre && best_grp && !best_nmi;
            nmi_o       <= can_pre && best_grp && best_nmi;
        end
    end
endmodule

// File: rtl/vlr_pend_sel_chk.sv
// Module: vlr_pend_sel_chk
// Property checker bound to vlr_pend_sel. It observes the ports only and
// keeps a one-cycle copy of the group bits to relate lines to the entry.
module vlr_pend_sel_chk #(
    parameter int NUM_LR = 4,
    parameter int NMI_EN = 1,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_LR-1:0] lr_group_i,
    input logic              hyp_en_i,
    input logic              act_nmi_i,
    input logic [IDX_W-1:0]  sel_idx_o,
    input logic              sel_valid_o,
    input logic              fiq_o,
    input logic              irq_o,
    input logic              nmi_o
);
    logic [NUM_LR-1:0] grp_q;

    // Group bits as seen at the previous edge.
    always_ff @(posedge clk) grp_q <= lr_group_i;

    // R9
    lines_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fiq_o, irq_o, nmi_o}));
    // R9
    fiq_grp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> !grp_q[sel_idx_o]);
    // R9
    irqnmi_grp1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || nmi_o) |-> grp_q[sel_idx_o]);
    // R2
    no_sel_no_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_o |-> !(fiq_o || irq_o || nmi_o));
    // R10
    hyp_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hyp_en_i |=> !(fiq_o || irq_o || nmi_o));
    // R8
    act_nmi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_nmi_i |=> !(fiq_o || irq_o || nmi_o));
    // R11
    nmi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (NMI_EN == 0) |-> !nmi_o);
endmodule

bind vlr_pend_sel vlr_pend_sel_chk #(.NUM_LR(NUM_LR), .NMI_EN(NMI_EN)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lr_group_i  (lr_group_i),
    .hyp_en_i    (hyp_en_i),
    .act_nmi_i   (act_nmi_i),
    .sel_idx_o   (sel_idx_o),
    .sel_valid_o (sel_valid_o),
    .fiq_o       (fiq_o),
    .irq_o       (irq_o),
    .nmi_o       (nmi_o)
);

// File: tb/test_vlr_pend_sel.sv
// Directed bench for vlr_pend_sel: two copies (NMI support on and off)
// share all stimulus. Inputs change just after a falling edge; results are
// sampled at the next falling edge, one rising edge later.
module test_vlr_pend_sel;
    localparam int N  = 4;
    localparam int PB = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0][1:0] st;
    logic [N-1:0]    grp;
    logic [N-1:0]    nmi;
    logic [N-1:0][7:0] pr;
    logic            g0en, g1en, hen, anmi;
    logic [7:0]      vpmr;
    logic [2:0]      bp0, bp1;
    logic [31:0]     apr;

    logic [1:0] idx_a, idx_b;
    logic       val_a, val_b, fiq_a, fiq_b, irq_a, irq_b, nmi_a, nmi_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    vlr_pend_sel #(.NUM_LR(N), .PRE_BITS(PB), .NMI_EN(1)) i_vlr_pend_sel (
        .clk(clk), .rst_n(rst_n), .lr_state_i(st), .lr_group_i(grp),
        .lr_nmi_i(nmi), .lr_prio_i(pr), .grp0_en_i(g0en), .grp1_en_i(g1en),
        .hyp_en_i(hen), .vpmr_i(vpmr), .bpr0_i(bp0), .bpr1_i(bp1),
        .apr_i(apr), .act_nmi_i(anmi), .sel_idx_o(idx_a), .sel_valid_o(val_a),
        .fiq_o(fiq_a), .irq_o(irq_a), .nmi_o(nmi_a));

    vlr_pend_sel #(.NUM_LR(N), .PRE_BITS(PB), .NMI_EN(0)) i_vlr_pend_sel_nonmi (
        .clk(clk), .rst_n(rst_n), .lr_state_i(st), .lr_group_i(grp),
        .lr_nmi_i(nmi), .lr_prio_i(pr), .grp0_en_i(g0en), .grp1_en_i(g1en),
        .hyp_en_i(hen), .vpmr_i(vpmr), .bpr0_i(bp0), .bpr1_i(bp1),
        .apr_i(apr), .act_nmi_i(anmi), .sel_idx_o(idx_b), .sel_valid_o(val_b),
        .fiq_o(fiq_b), .irq_o(irq_b), .nmi_o(nmi_b));

    task automatic defaults();
        st = '0; grp = '0; nmi = '0; pr = '0;
        g0en = 1; g1en = 1; hen = 1; anmi = 0;
        vpmr = 8'hFF; bp0 = 0; bp1 = 0; apr = '0;
    endtask

    task automatic put(int i, logic [1:0] s, logic g, logic n, logic [7:0] p);
        st[i] = s; grp[i] = g; nmi[i] = n; pr[i] = p;
    endtask

    // Compare current outputs of one copy (alt=1: NMI support off).
    task automatic cmp(string tag, bit alt, bit v, int ix, bit f, bit i, bit n);
        logic [4:0] got, exp;
        logic [1:0] gi;
        gi  = alt ? idx_b : idx_a;
        got = alt ? {val_b, fiq_b, irq_b, nmi_b, 1'b0} : {val_a, fiq_a, irq_a, nmi_a, 1'b0};
        exp = {v, f, i, n, 1'b0};
        checks++;
        if (got !== exp || (v && gi !== 2'(ix))) begin
            fails++;
            $display("FAIL %s: got valid/fiq/irq/nmi=%b idx=%0d, expected %b idx=%0d",
                     tag, got[4:1], gi, exp[4:1], ix);
        end
    endtask

    // Wait one rising edge and sample at the following falling edge.
    task automatic expect_out(string tag, bit alt, bit v, int ix, bit f, bit i, bit n);
        @(negedge clk);
        cmp(tag, alt, v, ix, f, i, n);
    endtask

    task automatic t_reset();
        defaults();
        put(0, 2'b01, 1, 0, 8'h10);
        repeat (3) @(negedge clk);
        cmp("R1 reset state", 0, 0, 0, 0, 0, 0);
        cmp("R1 reset state nonmi", 1, 0, 0, 0, 0, 0);
        checks++;
        if (idx_a !== 2'd0) begin
            fails++;
            $display("FAIL R1 reset idx: got %0d expected 0", idx_a);
        end
        rst_n = 1;
    endtask

    task automatic t_select();
        defaults();
        put(0, 2'b01, 1, 0, 8'h40); put(1, 2'b01, 1, 0, 8'h20);
        put(2, 2'b01, 1, 0, 8'h20); put(3, 2'b10, 1, 0, 8'h10);
        expect_out("R3 lowest prio, lower index on tie; R2 active skipped", 0, 1, 1, 0, 1, 0);
        st[3] = 2'b11;
        expect_out("R2 pending-and-active skipped", 0, 1, 1, 0, 1, 0);
        for (int i = 0; i < N; i++) put(i, 2'b01, 1, 0, 8'hFF);
        expect_out("R3 plain 0xFF never selected", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_groups();
        defaults();
        put(0, 2'b01, 0, 0, 8'h10); put(1, 2'b01, 1, 0, 8'h30);
        g0en = 0;
        expect_out("R2 group0 disabled", 0, 1, 1, 0, 1, 0);
        g0en = 1; g1en = 0;
        expect_out("R9 group0 drives fiq", 0, 1, 0, 1, 0, 0);
        g0en = 0;
        expect_out("R2 both groups disabled", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_nmi_tie();
        defaults();
        put(0, 2'b01, 1, 0, 8'h20); put(2, 2'b01, 1, 1, 8'h20);
        expect_out("R4 nmi wins tie, R9 nmi line", 0, 1, 2, 0, 0, 1);
        expect_out("R11 no tie win without nmi support", 1, 1, 0, 0, 1, 0);
        defaults();
        put(1, 2'b01, 1, 1, 8'hFF);
        expect_out("R4 nmi at 0xFF selectable", 0, 1, 1, 0, 0, 1);
        expect_out("R11 nmi at 0xFF not selected without support", 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_mask();
        defaults();
        vpmr = 8'h20;
        put(0, 2'b01, 1, 0, 8'h20);
        expect_out("R5 prio equal to mask blocked", 0, 1, 0, 0, 0, 0);
        nmi[0] = 1;
        expect_out("R5 nmi bypasses mask", 0, 1, 0, 0, 0, 1);
        expect_out("R11 nmi masked without support", 1, 1, 0, 0, 0, 0);
        nmi[0] = 0; pr[0] = 8'h1F;
        expect_out("R5 prio below mask passes", 0, 1, 0, 0, 1, 0);
    endtask

    task automatic t_preempt();
        defaults();
        apr = 32'h10;                      // running prio 0x20
        put(0, 2'b01, 1, 0, 8'h18);
        expect_out("R6 below running preempts", 0, 1, 0, 0, 1, 0);
        pr[0] = 8'h20;
        expect_out("R6 equal running blocked", 0, 1, 0, 0, 0, 0);
        nmi[0] = 1;
        expect_out("R7 nmi preempts at equal", 0, 1, 0, 0, 0, 1);
        nmi[0] = 0; pr[0] = 8'h18; bp1 = 3'd6;  // mask 0xC0
        expect_out("R6 group1 mask merges priorities", 0, 1, 0, 0, 0, 0);
        bp1 = 0; grp[0] = 0; pr[0] = 8'h1F;     // group0 mask 0xFE
        expect_out("R6 group0 mask 0xFE preempts", 0, 1, 0, 1, 0, 0);
        grp[0] = 1; pr[0] = 8'h18; apr = 32'h14; // running prio 0x10
        expect_out("R7 lowest active bit sets running prio", 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_actnmi();
        defaults();
        anmi = 1;
        put(0, 2'b01, 1, 1, 8'h00);
        expect_out("R8 active nmi blocks nmi at 0x00", 0, 1, 0, 0, 0, 0);
        nmi[0] = 0;
        expect_out("R8 active nmi blocks ordinary at 0x00", 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_hyp_latency();
        defaults();
        put(3, 2'b01, 1, 0, 8'h08);
        expect_out("R12 line set after one edge", 0, 1, 3, 0, 1, 0);
        hen = 0;
        #5;
        cmp("R12 output holds before edge", 0, 1, 3, 0, 1, 0);
        expect_out("R10 global enable off, selection kept", 0, 1, 3, 0, 0, 0);
    endtask

    initial begin
        defaults();
        @(negedge clk);
        t_reset();
        t_select();
        t_groups();
        t_nmi_tie();
        t_mask();
        t_preempt();
        t_actnmi();
        t_hyp_latency();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule